// File: doc/BRIEF.md
# Fragment Reassembling Receive Engine

This engine reads a message that a peer has split into fragments and placed, one 32-bit slot at a time, into a circular receive buffer. For each fragment it takes a header slot, which carries a 9-bit byte length and a "last fragment" flag. It waits until the whole payload is present in the buffer, then pops the payload slots and turns them into a stream of bytes, low byte first. A trailing partial slot gives up only its meaningful bytes. The engine keeps going, fragment after fragment, until it sees the last-fragment flag, meets an error, or uses up the byte budget the caller gave it.

The caller pulses `start` and supplies the byte budget in `max_len`. The engine first waits for the peer to report ready, and allows a bounded number of timed attempts. The buffer side supplies the count of filled slots and the slot at the read pointer, and the engine answers with a one-cycle `slot_pop`. When a non-last fragment has been consumed and the buffer is empty, the engine pulses `doorbell` to ask the peer for more. At the end, `done` pulses for one cycle, with `ok` or `err` and the total byte count held until the next start.

Top module: `frag_rx_engine`

## Requirements
- R1: The engine pops a header slot only when `fill_cnt` is nonzero. It takes the byte length from header bits 24:16 and the last-fragment flag from bit 31, and ignores every other header bit.
- R2: After a header with length L, no payload slot is popped until `fill_cnt` is at least ceil(L/4).
- R3: Payload bytes leave on `byte_data`, least significant byte of each slot first. Whole slots come first. From the final slot, only its low (L mod 4) bytes are emitted.
- R4: If a fragment's length exceeds the budget still left, the receive ends with `err` and pops none of that fragment's payload.
- R5: Once the whole slots of a fragment are drained, `peer_rdy` is sampled. If it is low, the receive ends with `err` and the final partial slot is not popped.
- R6: When a non-last fragment ends with budget left and `fill_cnt` equal to zero, `doorbell` is high for exactly one cycle. It stays low if the buffer still holds slots.
- R7: Fragments are joined in order. A fragment carrying the last flag ends the receive with `ok`, and `total_len` then equals the sum of all fragment lengths.
- R8: A non-last fragment that uses up the budget exactly ends the receive with `err`.
- R9: While `peer_rdy` is low at the start, the engine makes MAX_TRY attempts of RDY_WAIT cycles each (5 x 16 by default). It fails once they are all used, and proceeds at once if ready rises during any attempt.
- R10: A zero-length fragment is accepted. It emits no bytes and pulses `zero_warn` for one cycle.
- R11: While `byte_valid` is high and `byte_ready` is low, `byte_data` holds steady. No slot is popped while a byte is pending.
- R12: After reset the engine is idle: `busy`, `slot_pop`, `byte_valid`, `doorbell` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a receive (sampled while idle) |
| max_len | input | BUDGET_W | Byte budget for the whole message |
| fill_cnt | input | CNT_W | Number of filled slots in the receive buffer |
| slot_data | input | 32 | Slot at the buffer read pointer |
| peer_rdy | input | 1 | Peer reports ready |
| slot_pop | output | 1 | Consume the slot at the read pointer this cycle |
| byte_valid | output | 1 | Output byte available |
| byte_data | output | 8 | Output byte |
| byte_ready | input | 1 | Sink accepts the byte |
| doorbell | output | 1 | One-cycle request for more data |
| zero_warn | output | 1 | One-cycle flag for a zero-length fragment |
| done | output | 1 | One-cycle end-of-receive pulse |
| ok | output | 1 | Last receive succeeded (held) |
| err | output | 1 | Last receive failed (held) |
| total_len | output | BUDGET_W | Bytes accepted so far / in the finished message |
| busy | output | 1 | A receive is in progress |

## Verification
The bench targets the points where a slot engine slips by one. It uses lengths of 1, 5 and 511 bytes, where an engine that rounds the tail wrongly emits padding bytes or drops real ones. It uses a fragment that uses the budget exactly, where a comparison off by one would either reject a legal fragment or accept an incomplete message. It holds back part of a payload and drops peer readiness in the middle of a fragment: an engine that pops early would read stale slots, and one that skips the readiness check would read past the failure. It also times the readiness attempts, so that a wrong attempt count moves the failure earlier or turns a late-ready success into a failure. Throttled `byte_ready` runs through the whole table, so any pop made while a byte is still pending shows up as a lost or reordered byte.

// File: rtl/frag_rx_pkg.sv
package frag_rx_pkg;

    // Slot and header layout the peer encodes; positions are behaviour.
    localparam int SLOT_W     = 32;
    localparam int SLOT_BYTES = SLOT_W / 8;
    localparam int LEN_W      = 9;
    localparam int LEN_LSB    = 16;
    localparam int LAST_BIT   = 31;
    localparam int NB_W       = $clog2(SLOT_BYTES + 1);

    typedef enum logic [3:0] {
        S_IDLE, S_READY, S_HWAIT, S_HDEC, S_PWAIT,
        S_BODY, S_DRAIN, S_FEND, S_FIN
    } rx_state_t;

    typedef struct packed {
        logic             last;
        logic [LEN_W-1:0] len;
    } frag_hdr_t;

    function automatic frag_hdr_t decode_hdr(input logic [SLOT_W-1:0] w);
        frag_hdr_t h;
        h.last = w[LAST_BIT];
        h.len  = w[LEN_LSB +: LEN_W];
        return h;
    endfunction

    function automatic logic [LEN_W:0] slots_for(input logic [LEN_W-1:0] len);
        logic [LEN_W:0] ext;
        ext = {1'b0, len} + (LEN_W+1)'(SLOT_BYTES - 1);
        return ext >> $clog2(SLOT_BYTES);
    endfunction

endpackage

// File: rtl/frag_rx_hdr_dec.sv
module frag_rx_hdr_dec
    import frag_rx_pkg::*;
(
    input  logic [SLOT_W-1:0] hdr_word,
    output frag_hdr_t         hdr,
    output logic [LEN_W:0]    n_slots,
    output logic [LEN_W-1:0]  n_whole,
    output logic [NB_W-1:0]   n_tail
);
    localparam int SH = $clog2(SLOT_BYTES);

    always_comb begin
        hdr     = decode_hdr(hdr_word);
        n_slots = slots_for(hdr.len);
        n_whole = hdr.len >> SH;
        n_tail  = NB_W'(hdr.len[SH-1:0]);
    end
endmodule

// File: rtl/frag_rx_unpack.sv
module frag_rx_unpack
    import frag_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SLOT_W-1:0] load_word,
    input  logic [NB_W-1:0]   load_n,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready,
    output logic              busy
);
    logic [SLOT_W-1:0] shreg;
    logic [NB_W-1:0]   left;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            left  <= '0;
        end else if (load) begin
            shreg <= load_word;
            left  <= load_n;
        end else if (left != '0 && out_ready) begin
            shreg <= shreg >> 8;
            left  <= left - NB_W'(1);
        end
    end

    assign out_valid = (left != '0);
    assign out_data  = shreg[7:0];
    assign busy      = out_valid;
endmodule

// File: rtl/frag_rx_ctrl.sv
module frag_rx_ctrl
    import frag_rx_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int BUDGET_W = 10,
    parameter int MAX_TRY  = 5,
    parameter int RDY_WAIT = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [BUDGET_W-1:0] max_len,
    input  logic [CNT_W-1:0]    fill_cnt,
    input  logic [SLOT_W-1:0]   slot_data,
    input  logic                peer_rdy,
    input  frag_hdr_t           hdr,
    input  logic [LEN_W:0]      n_slots,
    input  logic [LEN_W-1:0]    n_whole,
    input  logic [NB_W-1:0]     n_tail,
    input  logic                unp_busy,
    output logic [SLOT_W-1:0]   hdr_word,
    output logic                slot_pop,
    output logic                unp_load,
    output logic [NB_W-1:0]     unp_n,
    output logic                doorbell,
    output logic                zero_warn,
    output logic                done,
    output logic                ok,
    output logic                err,
    output logic [BUDGET_W-1:0] total_len,
    output logic                busy
);
    localparam int TRY_W  = $clog2(MAX_TRY + 1);
    localparam int WAIT_W = $clog2(RDY_WAIT + 1);

    rx_state_t           state;
    logic [TRY_W-1:0]    tries;
    logic [WAIT_W-1:0]   wcnt;
    logic [BUDGET_W-1:0] remain;
    logic [LEN_W-1:0]    whole_left;
    logic                too_long;

    assign too_long = BUDGET_W'(hdr.len) > remain;

    always_comb begin
        slot_pop  = 1'b0;
        unp_load  = 1'b0;
        unp_n     = '0;
        doorbell  = 1'b0;
        zero_warn = 1'b0;
        done      = 1'b0;
        case (state)
            S_HWAIT: slot_pop = (fill_cnt != '0);
            S_HDEC:  zero_warn = (hdr.len == '0) && !too_long;
            S_BODY: begin
                if (!unp_busy) begin
                    if (whole_left != '0) begin
                        slot_pop = 1'b1;
                        unp_load = 1'b1;
                        unp_n    = NB_W'(SLOT_BYTES);
                    end else if (peer_rdy && n_tail != '0) begin
                        slot_pop = 1'b1;
                        unp_load = 1'b1;
                        unp_n    = n_tail;
                    end
                end
            end
            S_FEND:  doorbell = !hdr.last && (remain != '0) && (fill_cnt == '0);
            S_FIN:   done = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            tries      <= '0;
            wcnt       <= '0;
            remain     <= '0;
            whole_left <= '0;
            hdr_word   <= '0;
            total_len  <= '0;
            ok         <= 1'b0;
            err        <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    remain    <= max_len;
                    total_len <= '0;
                    tries     <= '0;
                    wcnt      <= '0;
                    ok        <= 1'b0;
                    err       <= 1'b0;
                    state     <= S_READY;
                end
                S_READY: begin
                    if (peer_rdy) begin
                        state <= S_HWAIT;
                    end else if (wcnt == WAIT_W'(RDY_WAIT - 1)) begin
                        wcnt <= '0;
                        if (tries == TRY_W'(MAX_TRY - 1)) begin
                            err   <= 1'b1;
                            state <= S_FIN;
                        end else begin
                            tries <= tries + TRY_W'(1);
                        end
                    end else begin
                        wcnt <= wcnt + WAIT_W'(1);
                    end
                end
                S_HWAIT: if (fill_cnt != '0) begin
                    hdr_word <= slot_data;
                    state    <= S_HDEC;
                end
                S_HDEC: begin
                    if (too_long) begin
                        err   <= 1'b1;
                        state <= S_FIN;
                    end else begin
                        remain     <= remain - BUDGET_W'(hdr.len);
                        total_len  <= total_len + BUDGET_W'(hdr.len);
                        whole_left <= n_whole;
                        state      <= (hdr.len == '0) ? S_FEND : S_PWAIT;
                    end
                end
                S_PWAIT: if (32'(fill_cnt) >= 32'(n_slots)) state <= S_BODY;
                S_BODY: if (!unp_busy) begin
                    if (whole_left != '0) begin
                        whole_left <= whole_left - LEN_W'(1);
                    end else if (!peer_rdy) begin
                        err   <= 1'b1;
                        state <= S_FIN;
                    end else begin
                        state <= S_DRAIN;
                    end
                end
                S_DRAIN: if (!unp_busy) state <= S_FEND;
                S_FEND: begin
                    if (hdr.last) begin
                        ok    <= 1'b1;
                        state <= S_FIN;
                    end else if (remain == '0) begin
                        err   <= 1'b1;
                        state <= S_FIN;
                    end else begin
                        state <= S_HWAIT;
                    end
                end
                S_FIN:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy = (state != S_IDLE);
endmodule

// File: rtl/frag_rx_engine.sv
module frag_rx_engine
    import frag_rx_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int BUDGET_W = 10,
    parameter int MAX_TRY  = 5,
    parameter int RDY_WAIT = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [BUDGET_W-1:0] max_len,
    input  logic [CNT_W-1:0]    fill_cnt,
    input  logic [31:0]         slot_data,
    input  logic                peer_rdy,
    output logic                slot_pop,
    output logic                byte_valid,
    output logic [7:0]          byte_data,
    input  logic                byte_ready,
    output logic                doorbell,
    output logic                zero_warn,
    output logic                done,
    output logic                ok,
    output logic                err,
    output logic [BUDGET_W-1:0] total_len,
    output logic                busy
);
    logic [SLOT_W-1:0] hdr_word;
    frag_hdr_t         hdr;
    logic [LEN_W:0]    n_slots;
    logic [LEN_W-1:0]  n_whole;
    logic [NB_W-1:0]   n_tail;
    logic              unp_load;
    logic [NB_W-1:0]   unp_n;
    logic              unp_busy;

    frag_rx_hdr_dec u_dec (
        .hdr_word (hdr_word),
        .hdr      (hdr),
        .n_slots  (n_slots),
        .n_whole  (n_whole),
        .n_tail   (n_tail)
    );

    frag_rx_ctrl #(
        .CNT_W    (CNT_W),
        .BUDGET_W (BUDGET_W),
        .MAX_TRY  (MAX_TRY),
        .RDY_WAIT (RDY_WAIT)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .max_len   (max_len),
        .fill_cnt  (fill_cnt),
        .slot_data (slot_data),
        .peer_rdy  (peer_rdy),
        .hdr       (hdr),
        .n_slots   (n_slots),
        .n_whole   (n_whole),
        .n_tail    (n_tail),
        .unp_busy  (unp_busy),
        .hdr_word  (hdr_word),
        .slot_pop  (slot_pop),
        .unp_load  (unp_load),
        .unp_n     (unp_n),
        .doorbell  (doorbell),
        .zero_warn (zero_warn),
        .done      (done),
        .ok        (ok),
        .err       (err),
        .total_len (total_len),
        .busy      (busy)
    );

    frag_rx_unpack u_unp (
        .clk       (clk),
        .rst       (rst),
        .load      (unp_load),
        .load_word (slot_data),
        .load_n    (unp_n),
        .out_valid (byte_valid),
        .out_data  (byte_data),
        .out_ready (byte_ready),
        .busy      (unp_busy)
    );
endmodule

// File: rtl/frag_rx_chk.sv
module frag_rx_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] fill_cnt,
    input logic             slot_pop,
    input logic             byte_valid,
    input logic [7:0]       byte_data,
    input logic             byte_ready,
    input logic             doorbell,
    input logic             done,
    input logic             ok,
    input logic             err,
    input logic             busy
);
    p_pop_needs_fill_r1: assert property (@(posedge clk) disable iff (rst)
        slot_pop |-> fill_cnt != '0);

    p_no_pop_pending_r11: assert property (@(posedge clk) disable iff (rst)
        slot_pop |-> !byte_valid);

    p_hold_byte_r11: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));

    p_one_verdict_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (ok != err));

    p_bell_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        doorbell |=> !doorbell);

    p_bell_empty_r6: assert property (@(posedge clk) disable iff (rst)
        doorbell |-> fill_cnt == '0);

    p_idle_after_reset_r12: assert property (@(posedge clk)
        rst |=> !busy);
endmodule

bind frag_rx_engine frag_rx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fill_cnt   (fill_cnt),
    .slot_pop   (slot_pop),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_ready (byte_ready),
    .doorbell   (doorbell),
    .done       (done),
    .ok         (ok),
    .err        (err),
    .busy       (busy)
);

// File: tb/sim_frag_rx_engine.sv
`timescale 1ns/1ps
module sim_frag_rx_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [9:0]  max_len = '0;
    logic [7:0]  fill_cnt = '0;
    logic [31:0] slot_data = '0;
    logic        peer_rdy = 1'b1;
    logic        byte_ready = 1'b1;
    logic        slot_pop, byte_valid, doorbell, zero_warn, done, ok, err, busy;
    logic [7:0]  byte_data;
    logic [9:0]  total_len;

    always #4 clk = ~clk;

    frag_rx_engine u0 (
        .clk(clk), .rst(rst), .start(start), .max_len(max_len),
        .fill_cnt(fill_cnt), .slot_data(slot_data), .peer_rdy(peer_rdy),
        .slot_pop(slot_pop), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_ready(byte_ready), .doorbell(doorbell), .zero_warn(zero_warn),
        .done(done), .ok(ok), .err(err), .total_len(total_len), .busy(busy)
    );

    // Buffer model and observers
    logic [31:0] q [0:255];
    logic [7:0]  expb [0:1023];
    logic [7:0]  got  [0:1023];
    int rd = 0, avail = 0, nwords = 0, nexp = 0;
    int nb = 0, pops = 0, pend_pops = 0, dbs = 0, zws = 0, cyc = 0;
    int bp_mode = 0;
    logic pop_mark = 1'b0, done_seen = 1'b0, r_ok = 1'b0, r_err = 1'b0;
    logic [9:0] r_tot = '0;
    int checks = 0, fails = 0;

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (pop_mark) rd++;
            fill_cnt  = (avail > rd) ? ((avail - rd > 255) ? 8'd255 : 8'(avail - rd)) : 8'd0;
            slot_data = q[rd[7:0]];
            case (bp_mode)
                1: byte_ready = (cyc % 3) != 2;
                2: byte_ready = 1'b0;
                default: byte_ready = 1'b1;
            endcase
            #1;
            pop_mark = slot_pop;
            if (slot_pop) pops++;
            if (slot_pop && byte_valid) pend_pops++;
            if (byte_valid && byte_ready) begin
                got[nb[9:0]] = byte_data;
                nb++;
            end
            if (doorbell) dbs++;
            if (zero_warn) zws++;
            if (done) begin
                done_seen = 1'b1;
                r_ok = ok; r_err = err; r_tot = total_len;
            end
        end
    end

    // Header: bit31 last, 30:25 junk ones/zeros, 24:16 length, 15:0 junk
    task automatic add_frag(input int len, input bit last, input int seed);
        q[nwords[7:0]] = {last, 6'b101010, 9'(len), 16'hA53C};
        nwords++;
        for (int w = 0; w < (len + 3) / 4; w++) begin
            logic [31:0] word;
            word = 32'hEEEEEEEE;
            for (int b = 0; b < 4; b++) begin
                if (w * 4 + b < len) begin
                    word[b*8 +: 8] = 8'((seed * 37 + nexp * 5 + 1) & 255);
                    expb[nexp[9:0]] = word[b*8 +: 8];
                    nexp++;
                end
            end
            q[nwords[7:0]] = word;
            nwords++;
        end
    endtask

    task automatic clear_case();
        @(posedge clk); #1;
        rd = 0; avail = 0; nwords = 0; nexp = 0; nb = 0; pops = 0;
        dbs = 0; zws = 0; done_seen = 1'b0;
    endtask

    task automatic kick(input int budget);
        @(posedge clk); #1;
        max_len = 10'(budget);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done_seen && n < 3000) begin
            @(posedge clk);
            n++;
        end
        chk(done_seen, "done-timeout", 0, 1);
        repeat (2) @(posedge clk);
    endtask

    task automatic chk_bytes(input string req, input int count);
        chk(nb == count, req, nb, count);
        for (int i = 0; i < count && i < nb; i++)
            chk(got[i] == expb[i], req, int'(got[i]), int'(expb[i]));
    endtask

    typedef struct packed {
        logic [1:0]  nfr;
        logic [8:0]  l0, l1, l2;
        logic [9:0]  budget;
        logic        exp_ok;
        logic [9:0]  exp_tot;
        logic [9:0]  exp_nb;
        logic [1:0]  exp_zw;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{2'd1, 9'd8,   9'd0,  9'd0, 10'd100, 1'b1, 10'd8,   10'd8,   2'd0}, // R3 whole slots
        '{2'd1, 9'd5,   9'd0,  9'd0, 10'd100, 1'b1, 10'd5,   10'd5,   2'd0}, // R3 tail
        '{2'd3, 9'd7,   9'd4,  9'd3, 10'd100, 1'b1, 10'd14,  10'd14,  2'd0}, // R7 join
        '{2'd1, 9'd1,   9'd0,  9'd0, 10'd1,   1'b1, 10'd1,   10'd1,   2'd0}, // R4 exact fit
        '{2'd2, 9'd6,   9'd10, 9'd0, 10'd12,  1'b0, 10'd0,   10'd6,   2'd0}, // R4 too long
        '{2'd2, 9'd0,   9'd3,  9'd0, 10'd100, 1'b1, 10'd3,   10'd3,   2'd1}, // R10 zero len
        '{2'd1, 9'd511, 9'd0,  9'd0, 10'd511, 1'b1, 10'd511, 10'd511, 2'd0}, // R1 max len
        '{2'd2, 9'd4,   9'd4,  9'd0, 10'd4,   1'b0, 10'd0,   10'd4,   2'd0}  // R8 exhausted
    };

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        repeat (4) @(posedge clk);
        #1;
        // R12: reset state
        chk(!busy && !slot_pop && !byte_valid && !doorbell && !done, "R12 reset idle",
            int'({busy, slot_pop, byte_valid, doorbell, done}), 0);
        rst = 1'b0;
        repeat (3) @(posedge clk); #1;
        chk(!busy && pops == 0, "R12 idle without start", pops, 0);

        // Table walk, throttled sink (R11)
        bp_mode = 1;
        for (int v = 0; v < 8; v++) begin
            vec_t t;
            t = VECS[v];
            clear_case();
            add_frag(int'(t.l0), t.nfr == 2'd1, v);
            if (t.nfr >= 2'd2) add_frag(int'(t.l1), t.nfr == 2'd2, v);
            if (t.nfr == 2'd3) add_frag(int'(t.l2), 1'b1, v);
            avail = nwords;
            kick(int'(t.budget));
            wait_done(n);
            chk(r_ok == t.exp_ok && r_err == !t.exp_ok, "R7 verdict (R4 R8 on fail vectors)",
                int'(r_ok), int'(t.exp_ok));
            if (t.exp_ok) chk(r_tot == t.exp_tot, "R7 total", int'(r_tot), int'(t.exp_tot));
            chk_bytes("R3 byte stream", int'(t.exp_nb));
            chk(zws == int'(t.exp_zw), "R10 zero warn", zws, int'(t.exp_zw));
            chk(dbs == 0, "R6 no doorbell with data buffered", dbs, 0);
            if (v == 4) chk(pops == 4, "R4 no payload pop of oversize fragment", pops, 4);
        end
        chk(pend_pops == 0, "R11 pop while byte pending", pend_pops, 0);
        bp_mode = 0;

        // R2: payload held back
        clear_case();
        add_frag(12, 1'b1, 9);
        avail = 3;
        kick(100);
        repeat (30) @(posedge clk); #2;
        chk(pops == 1 && nb == 0, "R2 waits for full payload", pops, 1);
        avail = nwords;
        wait_done(n);
        chk(r_ok && pops == 4, "R2 completes after release", pops, 4);
        chk_bytes("R2 bytes", 12);

        // R6: doorbell on empty buffer between fragments
        clear_case();
        add_frag(3, 1'b0, 10);
        add_frag(2, 1'b1, 10);
        avail = 2;
        kick(100);
        n = 0;
        while (dbs == 0 && n < 200) begin @(posedge clk); n++; end
        repeat (5) @(posedge clk); #2;
        chk(dbs == 1, "R6 single doorbell", dbs, 1);
        chk(!done_seen, "R6 still waiting", int'(done_seen), 0);
        avail = nwords;
        wait_done(n);
        chk(r_ok && r_tot == 10'd5, "R6 R7 ok after refill", int'(r_tot), 5);
        chk(dbs == 1, "R6 no extra doorbell", dbs, 1);
        chk_bytes("R6 bytes", 5);

        // R5: peer drops before the partial slot
        clear_case();
        add_frag(6, 1'b1, 11);
        avail = nwords;
        bp_mode = 2;
        kick(100);
        repeat (12) @(posedge clk); #1;
        peer_rdy = 1'b0;
        bp_mode = 0;
        wait_done(n);
        chk(r_err && !r_ok, "R5 fail on not ready", int'(r_err), 1);
        chk(pops == 2, "R5 tail slot not popped", pops, 2);
        chk_bytes("R5 whole-slot bytes", 4);

        // R9: never ready
        clear_case();
        peer_rdy = 1'b0;
        kick(100);
        wait_done(n);
        chk(r_err, "R9 fail after attempts", int'(r_err), 1);
        chk(n >= 76 && n <= 86, "R9 attempt window", n, 81);
        chk(pops == 0, "R9 no pops", pops, 0);

        // R9: ready during last attempt
        clear_case();
        add_frag(4, 1'b1, 12);
        avail = nwords;
        kick(100);
        repeat (70) @(posedge clk); #1;
        peer_rdy = 1'b1;
        wait_done(n);
        chk(r_ok && r_tot == 10'd4, "R9 late ready succeeds", int'(r_ok), 1);
        chk_bytes("R9 bytes", 4);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule